// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

This block turns a recorded operation class, a stored result and a stored second operand into the five condition flags of a 32-bit integer core: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The arithmetic datapath does not work out flags when it executes. It records which kind of operation ran, the value it produced and the second operand it used. When the flags are actually needed, this block rebuilds the missing first operand from those two values and derives carry and overflow from it.

The core raises a one-cycle strobe with the class code and the two stored values. On the next clock edge the flag register takes the new flags. The extended add and subtract forms can only clear Z, never set it, so a chain of multi-word operations leaves Z set only when every word was zero. An unrecognised class code leaves the flag register alone and raises an error output for one cycle. The strobe and the error output are plain control pins. The block has no back-pressure and accepts one evaluation in every cycle.

Top module: `ccf_eval`

## Requirements
- R1: Reset (active-low `rst_n`) clears all five flags and the error output. The flag vector is packed with X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: The flag register changes only on the clock edge that ends a cycle with `upd_i` high. In every other cycle it holds its value, whatever the other inputs do.
- R3: Logic class (code 1): Z is set when the result is zero. Otherwise N takes the result's bit 31. V and C clear, and X keeps its previous value.
- R4: Add class (code 2): C is set when the result is unsigned-less-than the source. V is bit 31 of (source XOR result) AND NOT (rebuilt XOR source), with rebuilt = result - source. N and Z follow the R3 rule, and X takes C.
- R5: Subtract class (code 3): rebuilt = result + source. C is set when rebuilt is unsigned-less-than the source. V is bit 31 of (rebuilt XOR result) AND (rebuilt XOR source). N and Z follow the R3 rule, and X takes C.
- R6: Byte compare (code 4) and word compare (code 5) apply the R5 rule to the low 8 or 16 bits only. N is taken from bit 7 or bit 15, and Z, C and V also come from that width. Upper bits have no effect, and X keeps its previous value.
- R7: Add-with-extend (code 6): rebuilt = result - source - 1. C is set when the result is unsigned-less-than-or-equal to the source. V uses the R4 formula with this rebuilt value, and X takes C.
- R8: Subtract-with-extend (code 7): rebuilt = result + source + 1. C is set when rebuilt is unsigned-less-than-or-equal to the source. V uses the R5 formula, N comes from the result, and X takes C.
- R9: For codes 6 and 7 the new Z is the freshly computed Z ANDed with the previous Z.
- R10: Shift class (code 8): C is set when the source (the stored carry-out) is nonzero. V is cleared, N and Z follow the R3 rule, and X takes C.
- R11: Resolved class (code 0) loads the flag register with bits 4..0 of the result.
- R12: Codes 9 to 15 with the strobe leave all flags unchanged and drive `bad_cls_o` high for exactly the following cycle. A valid code leaves `bad_cls_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Evaluation strobe |
| cls_i | input | 4 | Recorded operation class code |
| res_i | input | 32 | Stored result value |
| src_i | input | 32 | Stored second operand or shift carry-out |
| flags_o | output | 5 | Flag register {X,N,Z,V,C} |
| bad_cls_o | output | 1 | One-cycle pulse after a strobe with an unknown code |

## Verification
The flag register is the only state, so any fault in it shows on `flags_o` one cycle after the strobe that wrote it, or on a later idle cycle if the register drifts. A wrong previous Z or X is hidden until an extended-arithmetic or compare class reads it. For that reason each table vector first loads a known flag word through the resolved class, so that sticky Z and the preserved X become visible within two strobes. Narrow compares are driven with junk in the upper bits, which exposes any mistake in width selection on the very next cycle.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int DATA_W = 32;
  localparam int CLS_W  = 4;
  localparam int FLAG_W = 5;
  localparam int NLANE  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_RESOLVED = 4'd0,
    CLS_LOGIC    = 4'd1,
    CLS_ADD      = 4'd2,
    CLS_SUB      = 4'd3,
    CLS_CMPB     = 4'd4,
    CLS_CMPW     = 4'd5,
    CLS_ADDX     = 4'd6,
    CLS_SUBX     = 4'd7,
    CLS_SHIFT    = 4'd8
  } ccf_cls_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_flags_t;

  function automatic int lane_width(input int lane);
    if (lane == 0) return 8;
    if (lane == 1) return 16;
    return DATA_W;
  endfunction
endpackage

// File: rtl/ccf_sub_rule.sv
module ccf_sub_rule #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  logic [W-1:0] rebuilt;
  logic [W-1:0] ovf_vec;

  always_comb begin
    rebuilt = res_i + src_i + {{(W-1){1'b0}}, cin_i};
    ovf_vec = (rebuilt ^ res_i) & (rebuilt ^ src_i);
    z_o     = (res_i == '0);
    n_o     = !z_o && res_i[W-1];
    v_o     = ovf_vec[W-1];
    c_o     = cin_i ? (rebuilt <= src_i) : (rebuilt < src_i);
  end
endmodule

// File: rtl/ccf_add_rule.sv
module ccf_add_rule #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  output logic         v_o,
  output logic         c_o
);
  logic [W-1:0] first_op;
  logic [W-1:0] ovf_vec;

  always_comb begin
    first_op = res_i - src_i - {{(W-1){1'b0}}, cin_i};
    ovf_vec  = (src_i ^ res_i) & ~(first_op ^ src_i);
    v_o      = ovf_vec[W-1];
    c_o      = cin_i ? (res_i <= src_i) : (res_i < src_i);
  end
endmodule

// File: rtl/ccf_next.sv
module ccf_next
  import ccf_pkg::*;
(
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] src_i,
  input  ccf_flags_t        cur_i,
  input  logic [NLANE-1:0]  ln_n_i,
  input  logic [NLANE-1:0]  ln_z_i,
  input  logic [NLANE-1:0]  ln_v_i,
  input  logic [NLANE-1:0]  ln_c_i,
  input  logic              add_v_i,
  input  logic              add_c_i,
  output ccf_flags_t        nxt_o,
  output logic              bad_o
);
  localparam int FULL = NLANE - 1;

  always_comb begin
    nxt_o = cur_i;
    bad_o = 1'b0;
    case (ccf_cls_e'(cls_i))
      CLS_RESOLVED: nxt_o = ccf_flags_t'(res_i[FLAG_W-1:0]);
      CLS_LOGIC: begin
        nxt_o.n = ln_n_i[FULL];
        nxt_o.z = ln_z_i[FULL];
        nxt_o.v = 1'b0;
        nxt_o.c = 1'b0;
      end
      CLS_ADD, CLS_ADDX: begin
        nxt_o.n = ln_n_i[FULL];
        nxt_o.z = ln_z_i[FULL];
        nxt_o.v = add_v_i;
        nxt_o.c = add_c_i;
        nxt_o.x = add_c_i;
      end
      CLS_SUB, CLS_SUBX: begin
        nxt_o.n = ln_n_i[FULL];
        nxt_o.z = ln_z_i[FULL];
        nxt_o.v = ln_v_i[FULL];
        nxt_o.c = ln_c_i[FULL];
        nxt_o.x = ln_c_i[FULL];
      end
      CLS_CMPB: begin
        nxt_o.n = ln_n_i[0];
        nxt_o.z = ln_z_i[0];
        nxt_o.v = ln_v_i[0];
        nxt_o.c = ln_c_i[0];
      end
      CLS_CMPW: begin
        nxt_o.n = ln_n_i[1];
        nxt_o.z = ln_z_i[1];
        nxt_o.v = ln_v_i[1];
        nxt_o.c = ln_c_i[1];
      end
      CLS_SHIFT: begin
        nxt_o.n = ln_n_i[FULL];
        nxt_o.z = ln_z_i[FULL];
        nxt_o.v = 1'b0;
        nxt_o.c = (src_i != '0);
        nxt_o.x = (src_i != '0);
      end
      default: bad_o = 1'b1;
    endcase
    // sticky zero for the extended forms
    if (cls_i == CLS_ADDX || cls_i == CLS_SUBX)
      nxt_o.z = ln_z_i[FULL] & cur_i.z;
  end
endmodule

// File: rtl/ccf_eval.sv
module ccf_eval
  import ccf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              bad_cls_o
);
  ccf_flags_t       flag_q;
  ccf_flags_t       flag_nxt;
  logic             bad_nxt;
  logic             bad_q;
  logic [NLANE-1:0] ln_n, ln_z, ln_v, ln_c;
  logic             add_v, add_c;
  logic             sub_cin, add_cin;

  assign sub_cin = (cls_i == CLS_SUBX);
  assign add_cin = (cls_i == CLS_ADDX);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = lane_width(g);
    ccf_sub_rule #(.W(LW)) u_sub (
      .res_i (res_i[LW-1:0]),
      .src_i (src_i[LW-1:0]),
      .cin_i ((g == NLANE-1) ? sub_cin : 1'b0),
      .n_o   (ln_n[g]),
      .z_o   (ln_z[g]),
      .v_o   (ln_v[g]),
      .c_o   (ln_c[g])
    );
  end

  ccf_add_rule #(.W(DATA_W)) u_add (
    .res_i (res_i),
    .src_i (src_i),
    .cin_i (add_cin),
    .v_o   (add_v),
    .c_o   (add_c)
  );

  ccf_next u_next (
    .cls_i   (cls_i),
    .res_i   (res_i),
    .src_i   (src_i),
    .cur_i   (flag_q),
    .ln_n_i  (ln_n),
    .ln_z_i  (ln_z),
    .ln_v_i  (ln_v),
    .ln_c_i  (ln_c),
    .add_v_i (add_v),
    .add_c_i (add_c),
    .nxt_o   (flag_nxt),
    .bad_o   (bad_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= upd_i & bad_nxt;
      if (upd_i && !bad_nxt) flag_q <= flag_nxt;
    end
  end

  assign flags_o   = flag_q;
  assign bad_cls_o = bad_q;
endmodule

// File: rtl/ccf_eval_chk.sv
module ccf_eval_chk
  import ccf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              upd_i,
  input logic [CLS_W-1:0]  cls_i,
  input logic [DATA_W-1:0] res_i,
  input logic [DATA_W-1:0] src_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              bad_cls_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(flags_o));

  // R3
  logic_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && cls_i == CLS_LOGIC) |=> (flags_o[2] == ($past(res_i) == '0)) && !flags_o[0]);

  // R9
  sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && (cls_i == CLS_ADDX || cls_i == CLS_SUBX) && !flags_o[2]) |=> !flags_o[2]);

  // R10
  shift_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && cls_i == CLS_SHIFT) |=> !flags_o[1] && (flags_o[0] == ($past(src_i) != '0)));

  // R12
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && cls_i > CLS_SHIFT) |=> bad_cls_o && $stable(flags_o));

  // R12
  bad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> !bad_cls_o);
endmodule

bind ccf_eval ccf_eval_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_i     (upd_i),
  .cls_i     (cls_i),
  .res_i     (res_i),
  .src_i     (src_i),
  .flags_o   (flags_o),
  .bad_cls_o (bad_cls_o)
);

// File: tb/ccf_eval_tb.sv
module ccf_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_i = 1'b0;
  logic [3:0]  cls_i = '0;
  logic [31:0] res_i = '0;
  logic [31:0] src_i = '0;
  logic [4:0]  flags_o;
  logic        bad_cls_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ccf_eval u_dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .cls_i(cls_i),
    .res_i(res_i), .src_i(src_i), .flags_o(flags_o), .bad_cls_o(bad_cls_o)
  );

  // {req[3:0], pre[4:0], cls[3:0], res[31:0], src[31:0], exp[4:0]}
  localparam int NV = 22;
  localparam logic [81:0] VEC [NV] = '{
    {4'd3,  5'h10, 4'd1, 32'h00000000, 32'h00000000, 5'h14}, // R3
    {4'd3,  5'h00, 4'd1, 32'h80000000, 32'h00000000, 5'h08}, // R3
    {4'd3,  5'h0F, 4'd1, 32'h00000001, 32'h00000000, 5'h00}, // R3
    {4'd4,  5'h00, 4'd2, 32'h80000000, 32'h00000001, 5'h0A}, // R4
    {4'd4,  5'h00, 4'd2, 32'h00000000, 32'h00000001, 5'h15}, // R4
    {4'd4,  5'h1F, 4'd2, 32'h00000008, 32'h00000003, 5'h00}, // R4
    {4'd5,  5'h00, 4'd3, 32'hFFFFFFFE, 32'h00000005, 5'h19}, // R5
    {4'd5,  5'h00, 4'd3, 32'h7FFFFFFF, 32'h00000001, 5'h02}, // R5
    {4'd5,  5'h10, 4'd3, 32'h00000000, 32'h00000007, 5'h04}, // R5
    {4'd6,  5'h10, 4'd4, 32'hABCDEF80, 32'h12345601, 5'h18}, // R6
    {4'd6,  5'h00, 4'd4, 32'hFFFFFF00, 32'h000000FF, 5'h04}, // R6
    {4'd6,  5'h00, 4'd5, 32'h55557FFF, 32'hAAAA0001, 5'h02}, // R6
    {4'd6,  5'h10, 4'd5, 32'h0000FFFF, 32'h00000002, 5'h19}, // R6
    {4'd9,  5'h04, 4'd6, 32'h00000000, 32'h00000000, 5'h15}, // R9
    {4'd9,  5'h00, 4'd6, 32'h00000000, 32'h00000000, 5'h11}, // R9
    {4'd7,  5'h04, 4'd6, 32'h80000000, 32'h00000000, 5'h0A}, // R7
    {4'd8,  5'h04, 4'd7, 32'hFFFFFFFF, 32'h00000000, 5'h19}, // R8
    {4'd9,  5'h04, 4'd7, 32'h00000000, 32'h00000004, 5'h04}, // R9
    {4'd9,  5'h10, 4'd7, 32'h00000000, 32'h00000004, 5'h00}, // R9
    {4'd10, 5'h02, 4'd8, 32'h80000000, 32'h00000001, 5'h19}, // R10
    {4'd10, 5'h1F, 4'd8, 32'h00000000, 32'h00000000, 5'h04}, // R10
    {4'd11, 5'h00, 4'd0, 32'hFFFFFF0B, 32'h00000000, 5'h0B}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one strobe; returns at the negedge after the registering edge
  task automatic strobe(input logic [3:0] c, input logic [31:0] r, input logic [31:0] s);
    @(negedge clk);
    upd_i = 1'b1; cls_i = c; res_i = r; src_i = s;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", {27'd0, flags_o}, 32'h0);
    check("R1 reset err", {31'd0, bad_cls_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      strobe(4'd0, {27'd0, VEC[i][77:73]}, 32'h0);
      strobe(VEC[i][72:69], VEC[i][68:37], VEC[i][36:5]);
      check($sformatf("R%0d vec %0d", VEC[i][81:78], i), {27'd0, flags_o}, {27'd0, VEC[i][4:0]});
      check($sformatf("R12 no err vec %0d", i), {31'd0, bad_cls_o}, 32'h0);
    end

    // R2: inputs move without the strobe, flags hold
    strobe(4'd0, 32'h0000000B, 32'h0);
    @(negedge clk);
    cls_i = 4'd1; res_i = 32'h0; src_i = 32'h5;
    repeat (3) @(negedge clk);
    check("R2 hold", {27'd0, flags_o}, 32'h0B);

    // R12: unknown codes
    strobe(4'd0, 32'h00000015, 32'h0);
    strobe(4'd9, 32'h0, 32'h1);
    check("R12 flags kept (9)", {27'd0, flags_o}, 32'h15);
    check("R12 err pulse (9)", {31'd0, bad_cls_o}, 32'h1);
    @(negedge clk);
    check("R12 err single cycle", {31'd0, bad_cls_o}, 32'h0);
    strobe(4'd15, 32'hFFFFFFFF, 32'h0);
    check("R12 flags kept (15)", {27'd0, flags_o}, 32'h15);
    check("R12 err pulse (15)", {31'd0, bad_cls_o}, 32'h1);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 re-reset flags", {27'd0, flags_o}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule